// File: doc/BRIEF.md
# I2C Master Start-Condition Generator

This block produces the bus Start condition for an I2C master. It observes SDA and SCL through a synchroniser and pulls SDA low through an open-drain output enable. It paces each step with a reloadable down-counter that is loaded from a divisor input. A one-cycle request first checks that both lines are idle high. The block then waits one counter period with SDA released, pulls SDA low while SCL stays high, and waits a second period. After that it stops the counter and keeps SDA low. The byte engine that follows takes the bus from that point.

A collision on either line aborts the sequence and returns the block to idle with SDA released. This applies to a line that is busy when the request arrives, to SCL falling during the first period, and to SDA low when that period ends. The completion event and the collision event each set a sticky flag that software clears with a strobe. A status bit records that an SDA fall with SCL high has been seen on the bus. A release strobe ends the hold phase.

Top module: `i2c_start_gen`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, start_en, sda_oe, start_seen, done_flag and coll_flag are all 0.
- R2: A start_req pulse in idle, with both synchronised lines high, sets start_en at the next edge. sda_oe then stays 0 for divisor+1 cycles.
- R3: When that first period ends, sda_oe (1 = pull SDA low) goes to 1 and stays at 1 for a second period of divisor+1 cycles.
- R4: At the edge that ends the second period, start_en clears and done_flag sets. sda_oe stays at 1 after that edge, with the counter stopped.
- R5: start_seen sets when the synchronised SDA goes from 1 to 0 while the synchronised SCL is 1. It clears when a request is accepted or when the hold is released.
- R6: A start_req in idle with either synchronised line at 0 does not start the sequence. coll_flag sets at the next edge.
- R7: The block aborts if the synchronised SCL is 0 on any cycle of the first period, or if the synchronised SDA is 0 on the cycle that period ends. On abort it clears start_en at the next edge, sets coll_flag, returns to idle and never asserts sda_oe.
- R8: done_flag and coll_flag are sticky. Each returns to 0 only through its active-high strobe (done_clr or coll_clr). If a flag is set and cleared in the same cycle, it ends at 1.
- R9: A divisor of 0 makes each of the two periods exactly one cycle long.
- R10: A start_req while start_en is 1, or while SDA is held, is ignored. The timing of the sequence in progress is unchanged and no flag is raised.
- R11: A release_req during the hold sets sda_oe to 0 at the next edge, returns the block to idle and clears start_seen.
- R12: sda_in and scl_in each pass through a two-flop synchroniser, so a line change affects decisions two edges later. For example, if SCL falls one cycle before a request, the request is still accepted, and the collision follows two edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle request to generate a Start |
| release_req | input | 1 | One-cycle strobe that ends the SDA hold |
| divisor | input | DIV_W | Counter reload value; a period is divisor+1 cycles |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| done_clr | input | 1 | Clear strobe for done_flag |
| coll_clr | input | 1 | Clear strobe for coll_flag |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| start_en | output | 1 | High while the two-period sequence runs |
| start_seen | output | 1 | A Start pattern was observed on the bus |
| done_flag | output | 1 | Sticky completion flag |
| coll_flag | output | 1 | Sticky bus-collision flag |

## Verification
The bench aims at the period boundaries. A divisor of 0 and a divisor of 255 would expose a design that counts divisor cycles instead of divisor+1, or that wraps the counter. It drops SCL one cycle before a request and mid-period, and drops SDA just before the first period ends. A design without the synchroniser delay would reject the request early, and one that ignores SDA at expiry would pull SDA low over another master. It also issues requests during the run and during the hold, and a flag clear in the same cycle as a new collision. A design that restarts, raises a false collision, or lets the clear win would break the cycle-by-cycle match with the reference model.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_FIRST  = 2'd1,
      ST_SECOND = 2'd2,
      ST_HOLD   = 2'd3
   } start_state_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned MAX_DIV_W       = 16;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          IDLE_LV = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= IDLE_LV;
               else        chain[gi] <= d;
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= IDLE_LV;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/i2c_baud_cnt.sv
module i2c_baud_cnt #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         run,
   input  logic [W-1:0] reload_val,
   output logic         expired
);

   localparam logic [W-1:0] ZERO = '0;
   localparam logic [W-1:0] ONE  = W'(1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt <= ZERO;
      else if (load)                cnt <= reload_val;
      else if (run && cnt != ZERO)  cnt <= cnt - ONE;
   end

   assign expired = run && (cnt == ZERO);

endmodule

// File: rtl/i2c_sticky_flag.sv
module i2c_sticky_flag #(
   parameter bit CLR_WINS = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);

   generate
      if (CLR_WINS) begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= 1'b0;
            else if (clr) q <= 1'b0;
            else if (set) q <= 1'b1;
         end
      end else begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= 1'b0;
            else if (set) q <= 1'b1;
            else if (clr) q <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
   import i2c_start_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic release_req,
   input  logic sda_sync,
   input  logic scl_sync,
   input  logic period_done,
   output logic cnt_load,
   output logic cnt_run,
   output logic busy,
   output logic sda_drive,
   output logic accept,
   output logic release_ack,
   output logic done_set,
   output logic coll_set
);

   start_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d     = state_q;
      cnt_load    = 1'b0;
      accept      = 1'b0;
      release_ack = 1'b0;
      done_set    = 1'b0;
      coll_set    = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (start_req) begin
               if (sda_sync && scl_sync) begin
                  state_d  = ST_FIRST;
                  cnt_load = 1'b1;
                  accept   = 1'b1;
               end else begin
                  coll_set = 1'b1;
               end
            end
         end
         ST_FIRST: begin
            if (!scl_sync) begin
               coll_set = 1'b1;
               state_d  = ST_IDLE;
            end else if (period_done) begin
               if (!sda_sync) begin
                  coll_set = 1'b1;
                  state_d  = ST_IDLE;
               end else begin
                  cnt_load = 1'b1;
                  state_d  = ST_SECOND;
               end
            end
         end
         ST_SECOND: begin
            if (period_done) begin
               done_set = 1'b1;
               state_d  = ST_HOLD;
            end
         end
         ST_HOLD: begin
            if (release_req) begin
               release_ack = 1'b1;
               state_d     = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign cnt_run   = (state_q == ST_FIRST) || (state_q == ST_SECOND);
   assign busy      = cnt_run;
   assign sda_drive = (state_q == ST_SECOND) || (state_q == ST_HOLD);

endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
   import i2c_start_pkg::*;
#(
   parameter int unsigned DIV_W         = 8,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter bit          FLAG_CLR_WINS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_req,
   input  logic             release_req,
   input  logic [DIV_W-1:0] divisor,
   input  logic             sda_in,
   input  logic             scl_in,
   input  logic             done_clr,
   input  logic             coll_clr,
   output logic             sda_oe,
   output logic             start_en,
   output logic             start_seen,
   output logic             done_flag,
   output logic             coll_flag
);

   generate
      if (DIV_W < 2 || DIV_W > MAX_DIV_W) begin : g_bad_div_w
         $error("i2c_start_gen: DIV_W out of supported range");
      end
      if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
         $error("i2c_start_gen: SYNC_STAGES below minimum");
      end
   endgenerate

   logic sda_sync, scl_sync;
   logic cnt_load, cnt_run, period_done;
   logic accept, release_ack, done_set, coll_set;
   logic sda_prev, seen_q;

   i2c_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_sync)
   );

   i2c_line_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_sync)
   );

   i2c_baud_cnt #(.W(DIV_W)) u_brg (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .run(cnt_run),
      .reload_val(divisor), .expired(period_done)
   );

   i2c_start_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .start_req(start_req), .release_req(release_req),
      .sda_sync(sda_sync), .scl_sync(scl_sync),
      .period_done(period_done),
      .cnt_load(cnt_load), .cnt_run(cnt_run),
      .busy(start_en), .sda_drive(sda_oe),
      .accept(accept), .release_ack(release_ack),
      .done_set(done_set), .coll_set(coll_set)
   );

   i2c_sticky_flag #(.CLR_WINS(FLAG_CLR_WINS)) u_done_flag (
      .clk(clk), .rst_n(rst_n), .set(done_set), .clr(done_clr), .q(done_flag)
   );

   i2c_sticky_flag #(.CLR_WINS(FLAG_CLR_WINS)) u_coll_flag (
      .clk(clk), .rst_n(rst_n), .set(coll_set), .clr(coll_clr), .q(coll_flag)
   );

   // Bus monitor: an SDA fall while SCL is high marks a Start.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_prev <= 1'b1;
         seen_q   <= 1'b0;
      end else begin
         sda_prev <= sda_sync;
         if (sda_prev && !sda_sync && scl_sync) seen_q <= 1'b1;
         else if (accept || release_ack)        seen_q <= 1'b0;
      end
   end

   assign start_seen = seen_q;

endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic start_req,
   input logic release_req,
   input logic sda_sync,
   input logic scl_sync,
   input logic sda_oe,
   input logic start_en,
   input logic done_flag,
   input logic coll_flag,
   input logic done_clr,
   input logic coll_clr
);

   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_en && !sda_oe && start_req && sda_sync && scl_sync) |=> (start_en && !sda_oe));

   p_busy_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_en && !sda_oe && start_req && !(sda_sync && scl_sync)) |=> (coll_flag && !start_en));

   p_scl_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_en && !sda_oe && !scl_sync) |=> (!start_en && !sda_oe && coll_flag));

   p_hold_sda_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe && !release_req) |=> sda_oe);

   p_done_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_flag) |-> (!start_en && sda_oe));

   p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_flag && !done_clr) |=> done_flag);

   p_coll_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (coll_flag && !coll_clr) |=> coll_flag);

   p_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe && !start_en && release_req) |=> !sda_oe);

endmodule

bind i2c_start_gen i2c_start_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start_req(start_req), .release_req(release_req),
   .sda_sync(sda_sync), .scl_sync(scl_sync), .sda_oe(sda_oe), .start_en(start_en),
   .done_flag(done_flag), .coll_flag(coll_flag), .done_clr(done_clr), .coll_clr(coll_clr)
);

// File: tb/i2c_start_gen_tb_top.sv
module i2c_start_gen_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_req = 1'b0, release_req = 1'b0;
   logic [7:0] divisor = 8'd3;
   logic       ext_sda = 1'b1, ext_scl = 1'b1;
   logic       done_clr = 1'b0, coll_clr = 1'b0;
   logic       sda_oe, start_en, start_seen, done_flag, coll_flag;
   logic       sda_line, scl_line;

   int n_checks = 0;
   int n_errors = 0;
   bit reported = 1'b0;

   always #5 clk = ~clk;

   // open-drain bus: the line is low if anyone pulls it
   assign sda_line = ext_sda & ~sda_oe;
   assign scl_line = ext_scl;

   i2c_start_gen dut_i (
      .clk(clk), .rst_n(rst_n), .start_req(start_req), .release_req(release_req),
      .divisor(divisor), .sda_in(sda_line), .scl_in(scl_line),
      .done_clr(done_clr), .coll_clr(coll_clr),
      .sda_oe(sda_oe), .start_en(start_en), .start_seen(start_seen),
      .done_flag(done_flag), .coll_flag(coll_flag)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      end
   endtask

   // ---------------- reference model ----------------
   int m_phase;          // 0 idle, 1 first period, 2 second period, 3 hold
   int m_rem;
   bit m_seen, m_done, m_coll, m_prev_sda;
   bit sda_pipe[$];
   bit scl_pipe[$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_rem = 0;
         m_seen = 0; m_done = 0; m_coll = 0; m_prev_sda = 1;
         sda_pipe = '{1'b1, 1'b1};
         scl_pipe = '{1'b1, 1'b1};
      end else begin
         bit ls, lc, ss, cs, dump;
         ls = ext_sda && !(m_phase >= 2);
         lc = ext_scl;
         ss = sda_pipe[0];
         cs = scl_pipe[0];
         if (done_clr) m_done = 0;
         if (coll_clr) m_coll = 0;
         if ((m_phase == 0 && start_req && ss && cs) || (m_phase == 3 && release_req))
            m_seen = 0;
         if (m_prev_sda && !ss && cs) m_seen = 1;
         case (m_phase)
            0: if (start_req) begin
                  if (ss && cs) begin m_phase = 1; m_rem = int'(divisor); end
                  else m_coll = 1;
               end
            1: if (!cs) begin m_coll = 1; m_phase = 0; end
               else if (m_rem == 0) begin
                  if (!ss) begin m_coll = 1; m_phase = 0; end
                  else begin m_phase = 2; m_rem = int'(divisor); end
               end else m_rem--;
            2: if (m_rem == 0) begin m_phase = 3; m_done = 1; end
               else m_rem--;
            default: if (release_req) m_phase = 0;
         endcase
         m_prev_sda = ss;
         sda_pipe.push_back(ls); dump = sda_pipe.pop_front();
         scl_pipe.push_back(lc); dump = scl_pipe.pop_front();
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 start_en vs model", int'(start_en), int'(m_phase == 1 || m_phase == 2));
         chk("R3 sda_oe vs model", int'(sda_oe), int'(m_phase >= 2));
         chk("R5 start_seen vs model", int'(start_seen), int'(m_seen));
         chk("R4 done_flag vs model", int'(done_flag), int'(m_done));
         chk("R7 coll_flag vs model", int'(coll_flag), int'(m_coll));
      end
   end

   // ---------------- stimulus helpers (called at a negedge) ----------------
   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic req();
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;
   endtask

   task automatic pulse_release();
      release_req = 1'b1; @(negedge clk); release_req = 1'b0;
      wait_n(3);
   endtask

   task automatic clear_flags();
      done_clr = 1'b1; coll_clr = 1'b1; @(negedge clk);
      done_clr = 1'b0; coll_clr = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 start_en in reset", int'(start_en), 0);
      chk("R1 sda_oe in reset", int'(sda_oe), 0);
      chk("R1 flags in reset", int'({start_seen, done_flag, coll_flag}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", int'({start_en, sda_oe, done_flag, coll_flag}), 0);

      // normal Start, divisor 3
      divisor = 8'd3;
      req();
      chk("R2 start_en after accept", int'(start_en), 1);
      chk("R2 sda released at start", int'(sda_oe), 0);
      wait_n(3);
      chk("R2 sda released through first period", int'(sda_oe), 0);
      wait_n(1);
      chk("R3 sda pulled after first period", int'(sda_oe), 1);
      wait_n(3);
      chk("R4 still busy in second period", int'(start_en), 1);
      chk("R4 done not early", int'(done_flag), 0);
      wait_n(1);
      chk("R4 start_en cleared", int'(start_en), 0);
      chk("R4 done_flag set", int'(done_flag), 1);
      chk("R4 sda held", int'(sda_oe), 1);
      wait_n(4);
      chk("R5 start_seen set", int'(start_seen), 1);

      // request during hold is ignored
      req();
      chk("R10 hold request no collision", int'(coll_flag), 0);
      chk("R10 hold request no restart", int'({start_en, sda_oe}), 1);
      wait_n(3);
      chk("R8 done stays set", int'(done_flag), 1);
      done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
      chk("R8 done cleared by strobe", int'(done_flag), 0);

      // release
      release_req = 1'b1; @(negedge clk); release_req = 1'b0;
      chk("R11 sda released", int'(sda_oe), 0);
      chk("R11 start_seen cleared", int'(start_seen), 0);
      wait_n(3);

      // divisor 0
      divisor = 8'd0;
      req();
      chk("R9 busy, sda released", int'({start_en, sda_oe}), 2);
      wait_n(1);
      chk("R9 one-cycle first period", int'({start_en, sda_oe}), 3);
      wait_n(1);
      chk("R9 one-cycle second period", int'({start_en, done_flag}), 1);
      clear_flags();
      pulse_release();

      // request during first period is ignored
      divisor = 8'd5;
      req();
      start_req = 1'b1; @(negedge clk); start_req = 1'b0;
      wait_n(4);
      chk("R10 first period length kept", int'(sda_oe), 0);
      wait_n(1);
      chk("R10 sda pulled on time", int'(sda_oe), 1);
      wait_n(5);
      chk("R10 still busy", int'(start_en), 1);
      wait_n(1);
      chk("R10 done on time", int'(done_flag), 1);
      chk("R10 no collision", int'(coll_flag), 0);
      clear_flags();
      pulse_release();

      // busy SDA at request
      ext_sda = 1'b0; wait_n(3);
      req();
      chk("R6 collision on low SDA", int'(coll_flag), 1);
      chk("R6 no sequence", int'({start_en, sda_oe}), 0);
      start_req = 1'b1; coll_clr = 1'b1; @(negedge clk);
      start_req = 1'b0; coll_clr = 1'b0;
      chk("R8 set wins over clear", int'(coll_flag), 1);
      coll_clr = 1'b1; @(negedge clk); coll_clr = 1'b0;
      chk("R8 coll cleared by strobe", int'(coll_flag), 0);
      ext_sda = 1'b1; ext_scl = 1'b0; wait_n(3);
      req();
      chk("R6 collision on low SCL", int'(coll_flag), 1);
      ext_scl = 1'b1; wait_n(3);
      clear_flags();

      // SCL falls mid first period
      divisor = 8'd10;
      req();
      wait_n(3);
      ext_scl = 1'b0;
      wait_n(2);
      chk("R7 not yet aborted", int'({start_en, coll_flag}), 2);
      wait_n(1);
      chk("R7 aborted on SCL low", int'({start_en, sda_oe, coll_flag}), 1);
      ext_scl = 1'b1; wait_n(3);
      clear_flags();

      // SDA low when first period ends
      divisor = 8'd6;
      req();
      wait_n(2);
      ext_sda = 1'b0;
      wait_n(4);
      chk("R7 busy before expiry", int'({start_en, coll_flag}), 2);
      wait_n(1);
      chk("R7 aborted on SDA low at expiry", int'({start_en, sda_oe, coll_flag}), 1);
      ext_sda = 1'b1; wait_n(3);
      clear_flags();

      // synchroniser latency
      divisor = 8'd4;
      ext_scl = 1'b0; start_req = 1'b1; @(negedge clk); start_req = 1'b0;
      chk("R12 request accepted on stale sample", int'(start_en), 1);
      wait_n(1);
      chk("R12 no collision one edge later", int'({start_en, coll_flag}), 2);
      wait_n(1);
      chk("R12 collision two edges later", int'({start_en, coll_flag}), 1);
      ext_scl = 1'b1; wait_n(3);
      clear_flags();

      // largest divisor
      divisor = 8'd255;
      req();
      wait_n(2 * 256 + 4);
      chk("R4 done with divisor 255", int'({start_en, sda_oe, done_flag}), 3);
      clear_flags();
      pulse_release();

      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
      $finish;
   end

endmodule